// File: doc/BRIEF.md
# Sample Memory Access Sequencer

This block schedules the accesses that move audio samples into and out of a shared sample memory. Two slow sample clocks, one for storing and one for playing back, arrive asynchronously to a much faster main clock. Each rising edge of a sample clock raises a pending request that is held in a set/reset latch. An arbiter grants one request at a time. The granted operation runs a four-bit step counter through a fixed ten-step walk. The step value and a read/write select bit together address a 32-entry, 8-bit control table.

The table output is registered, and the strobes come from the registered word: row strobe, column strobe, memory write enable, read data capture and converter start. Counter bits 2 and 3 are registered in the same stage and give the nibble address bits for read and for write. An active-low end code in the table finishes the operation. It clears the granted request and advances that operation's sample pointer.

Top module: `sample_seq_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), busy, every strobe and both nibble bits are 0, step is 0, and both pointers are 0.
- R2: While busy, step takes the values 0,1,2,3,4,5,8,9,10,11 on successive cycles and then returns to 0. While not busy, step stays at 0 and never takes the values 6, 7 or 12 to 15.
- R3: Only one operation runs at a time, and op_is_rd keeps its value for the whole time busy is high.
- R4: When a write request and a read request are pending together, the write is granted first. The read stays pending and is granted afterwards.
- R5: A write operation pulses conv_start for exactly one cycle, in the first cycle after the grant. It pulses mem_we for one cycle in each of two separate accesses.
- R6: A read operation never raises conv_start or mem_we. It pulses cap_stb for one cycle in each of its two accesses.
- R7: Each finished write increments wr_ptr by one, and each finished read increments rd_ptr by one, both modulo 2^PTR_W.
- R8: The nibble bits are registered copies of counter bits, one cycle late: nib_rd equals bit 2 and nib_wr equals bit 3 of the previous cycle's step. During an operation, nib_wr is therefore high in output cycles 7 to 10 and nib_rd is high in output cycles 5 and 6.
- R9: A sample clock that stays high starts only one operation. A new operation needs a new rising edge.
- R10: One operation occupies 10 busy cycles. An operation that is already pending is granted on the cycle right after busy falls, so a write and a read complete within 22 main-clock cycles of the write grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main sequencing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_sclk | input | 1 | Asynchronous store sample clock; a rising edge requests a write |
| rd_sclk | input | 1 | Asynchronous playback sample clock; a rising edge requests a read |
| busy | output | 1 | An operation is granted and running |
| op_is_rd | output | 1 | Kind of the running operation: 1 read, 0 write |
| step | output | 4 | Current step counter value |
| row_stb | output | 1 | Registered row address strobe (active high) |
| col_stb | output | 1 | Registered column address strobe (active high) |
| mem_we | output | 1 | Registered memory write enable |
| cap_stb | output | 1 | Registered read-data capture strobe |
| conv_start | output | 1 | Registered converter start pulse |
| nib_rd | output | 1 | Read nibble address bit |
| nib_wr | output | 1 | Write nibble address bit |
| wr_ptr | output | PTR_W | Write sample pointer |
| rd_ptr | output | PTR_W | Read sample pointer |

## Verification
A corrupted step counter shows on the step port at the next edge. Because the strobes are table outputs one cycle behind the counter, it also shows in the strobe pattern one cycle later. A stuck or mis-cleared request latch shows either as a missing grant or as a repeated grant. In both cases the pointers then move by the wrong amount when busy falls. A wrong arbiter state shows as op_is_rd changing while busy is high, or as conv_start or mem_we appearing during a read. Each of these shows within one operation of about eleven cycles.

// File: rtl/seq_pkg.sv
// Package: shared constants for the sample access sequencer.
// Assumes a 4-bit step counter and an 8-bit control word.
package seq_pkg;
    localparam int STEP_W    = 4;
    localparam int CTRL_W    = 8;
    localparam int JUMP_FROM = 5;
    localparam int JUMP_TO   = 8;
    localparam int LAST_STEP = 11;

    // control word bit positions
    localparam int B_ROW  = 0;
    localparam int B_COL  = 1;
    localparam int B_WE   = 2;
    localparam int B_CONV = 3;
    localparam int B_ENDN = 4;
    localparam int B_CAP  = 5;

    localparam logic [CTRL_W-1:0] CTRL_IDLE = 8'h10;
endpackage

// File: rtl/req_catch.sv
// Module: req_catch
// Synchronises one asynchronous sample clock, detects its rising edge and
// holds the request in a set/reset latch until clr. Set wins over clear.
module req_catch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic clr,
    output logic pend
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            // one stage of the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else if (g == 0) sync_q[g] <= sclk;
                else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // remember the previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] && !last_q;

    // request latch: set by an edge, cleared by the end of the operation
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (rise) pend <= 1'b1;
        else if (clr)  pend <= 1'b0;
    end

    // R9: a request is only set by a fresh edge
    a_r9_set_by_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(rise));
endmodule

// File: rtl/step_counter.sv
// Module: step_counter
// Step counter that jumps from JUMP_FROM to JUMP_TO and wraps after LAST_STEP.
// Held at zero while not enabled.
module step_counter
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [STEP_W-1:0] cnt
);
    logic [STEP_W-1:0] nxt;

    // next-step selection including the jump
    always_comb begin
        if (!en)                                    nxt = '0;
        else if (cnt == STEP_W'(JUMP_FROM))         nxt = STEP_W'(JUMP_TO);
        else if (cnt == STEP_W'(LAST_STEP))         nxt = '0;
        else                                        nxt = cnt + 1'b1;
    end

    // step register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end

    // R2: only legal step values ever appear
    a_r2_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !(cnt inside {4'd6, 4'd7, 4'd12, 4'd13, 4'd14, 4'd15}));
endmodule

// File: rtl/ctrl_rom.sv
// Module: ctrl_rom
// Constant 32 x 8 control table. Address bit 4 is the read/write select
// (1 = read), so reads use the upper half. Unused steps give the idle word.
module ctrl_rom
    import seq_pkg::*;
(
    input  logic [4:0]        addr,
    output logic [CTRL_W-1:0] word
);
    // table lookup; bit0 row, bit1 col, bit2 we, bit3 conv, bit4 end_n, bit5 cap
    always_comb begin
        case (addr)
            5'h00: word = 8'h18;   // write: start conversion
            5'h02: word = 8'h11;   // row
            5'h03: word = 8'h13;   // row + col
            5'h04: word = 8'h17;   // row + col + write
            5'h08: word = 8'h11;
            5'h09: word = 8'h17;
            5'h0A: word = 8'h00;   // end of write
            5'h12: word = 8'h11;   // read: row
            5'h13: word = 8'h13;
            5'h14: word = 8'h33;   // capture first nibble
            5'h18: word = 8'h11;
            5'h19: word = 8'h33;   // capture second nibble
            5'h1A: word = 8'h00;   // end of read
            default: word = CTRL_IDLE;
        endcase
    end
endmodule

// File: rtl/sample_seq_top.sv
// Module: sample_seq_top
// Arbitrates write and read requests (write first), runs the step counter
// for the granted one, and registers control-table outputs and nibble bits.
// Assumes sample clocks are much slower than clk.
module sample_seq_top
    import seq_pkg::*;
#(
    parameter int PTR_W       = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sclk,
    input  logic             rd_sclk,
    output logic             busy,
    output logic             op_is_rd,
    output logic [3:0]       step,
    output logic             row_stb,
    output logic             col_stb,
    output logic             mem_we,
    output logic             cap_stb,
    output logic             conv_start,
    output logic             nib_rd,
    output logic             nib_wr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr
);
    logic              wr_pend, rd_pend;
    logic              active, sel_rd;
    logic [STEP_W-1:0] cnt;
    logic [CTRL_W-1:0] rom_word, ctrl_q;
    logic              nib_rd_q, nib_wr_q;
    logic              end_hit, clr_wr, clr_rd;

    assign end_hit = active && !ctrl_q[B_ENDN];
    assign clr_wr  = end_hit && !sel_rd;
    assign clr_rd  = end_hit &&  sel_rd;

    req_catch #(.SYNC_STAGES(SYNC_STAGES)) i_wr_req (
        .clk(clk), .rst_n(rst_n), .sclk(wr_sclk), .clr(clr_wr), .pend(wr_pend));
    req_catch #(.SYNC_STAGES(SYNC_STAGES)) i_rd_req (
        .clk(clk), .rst_n(rst_n), .sclk(rd_sclk), .clr(clr_rd), .pend(rd_pend));

    step_counter i_cnt (.clk(clk), .rst_n(rst_n), .en(active), .cnt(cnt));

    ctrl_rom i_rom (.addr({sel_rd, cnt}), .word(rom_word));

    // grant logic: write has priority, one operation at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sel_rd <= 1'b0;
        end else if (!active) begin
            if (wr_pend) begin
                active <= 1'b1;
                sel_rd <= 1'b0;
            end else if (rd_pend) begin
                active <= 1'b1;
                sel_rd <= 1'b1;
            end
        end else if (end_hit) begin
            active <= 1'b0;
        end
    end

    // output register stage for table word and counter bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_IDLE;
            nib_rd_q <= 1'b0;
            nib_wr_q <= 1'b0;
        end else begin
            ctrl_q   <= active ? rom_word : CTRL_IDLE;
            nib_rd_q <= active && cnt[2];
            nib_wr_q <= active && cnt[3];
        end
    end

    // sample pointers advanced by the end code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (clr_wr) wr_ptr <= wr_ptr + 1'b1;
            if (clr_rd) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign busy       = active;
    assign op_is_rd   = sel_rd;
    assign step       = cnt;
    assign row_stb    = ctrl_q[B_ROW];
    assign col_stb    = ctrl_q[B_COL];
    assign mem_we     = ctrl_q[B_WE];
    assign conv_start = ctrl_q[B_CONV];
    assign cap_stb    = ctrl_q[B_CAP];
    assign nib_rd     = nib_rd_q;
    assign nib_wr     = nib_wr_q;

    // R2: counter rests at zero while nothing is granted
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> cnt == '0);
    // R3: the kind of operation cannot change mid-operation
    a_r3_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
        active && $past(active) |-> $stable(sel_rd));
    // R5: converter start only in write operations
    a_r5_conv_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[B_CONV] |-> active && !sel_rd);
    // R6: capture and no write strobe in reads
    a_r6_read_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[B_CAP] |-> active && sel_rd && !ctrl_q[B_WE]);
    // R7: pointers only ever step by one
    a_r7_wr_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr != $past(wr_ptr) |-> wr_ptr == $past(wr_ptr) + 1'b1);
    a_r7_rd_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr != $past(rd_ptr) |-> rd_ptr == $past(rd_ptr) + 1'b1);
endmodule

// File: tb/test_sample_seq_top.sv
// Directed bench for sample_seq_top; one task per scenario.
module test_sample_seq_top;
    localparam int PW = 3;

    logic clk = 1'b0, rst_n = 1'b0, wr_sclk = 1'b0, rd_sclk = 1'b0;
    logic busy, op_is_rd, row_stb, col_stb, mem_we, cap_stb, conv_start, nib_rd, nib_wr;
    logic [3:0] step;
    logic [PW-1:0] wr_ptr, rd_ptr;
    int n_chk = 0, n_bad = 0;

    sample_seq_top #(.PTR_W(PW)) i_sample_seq_top (
        .clk(clk), .rst_n(rst_n), .wr_sclk(wr_sclk), .rd_sclk(rd_sclk),
        .busy(busy), .op_is_rd(op_is_rd), .step(step), .row_stb(row_stb),
        .col_stb(col_stb), .mem_we(mem_we), .cap_stb(cap_stb),
        .conv_start(conv_start), .nib_rd(nib_rd), .nib_wr(nib_wr),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr));

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_step(input int k);
        return (k <= 5) ? k : k + 2;
    endfunction

    // wait for busy at a falling edge; drops the sample clocks after 3 cycles
    task automatic wait_busy(input bit drop, output int waited);
        waited = 0;
        while (!busy && waited < 60) begin
            @(negedge clk);
            waited++;
            if (drop && waited == 3) begin wr_sclk = 1'b0; rd_sclk = 1'b0; end
        end
        if (drop) begin wr_sclk = 1'b0; rd_sclk = 1'b0; end
    endtask

    // follow one granted operation from its grant cycle to its end
    task automatic run_seq(input bit is_rd, input string tag);
        int bad_step = 0, conv_n = 0, we_n = 0, cap_n = 0, ras_n = 0;
        int nr_bad = 0, nw_bad = 0, conv_pos = -1, kind_bad = 0;
        chk({tag, " R2 step at grant"}, step, 0);
        chk({tag, " R3 kind"}, op_is_rd, is_rd);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k <= 9) begin
                if (step != exp_step(k) || !busy) bad_step++;
                if (op_is_rd != is_rd) kind_bad++;
            end else if (step != 0 || busy) bad_step++;
            if (conv_start) begin conv_n++; conv_pos = k; end
            if (mem_we) we_n++;
            if (cap_stb) cap_n++;
            if (row_stb) ras_n++;
            if (nib_wr != (k >= 7)) nw_bad++;
            if (nib_rd != (k == 5 || k == 6)) nr_bad++;
        end
        chk({tag, " R2 step walk"}, bad_step, 0);
        chk({tag, " R3 kind held"}, kind_bad, 0);
        chk({tag, " R8 nib_wr"}, nw_bad, 0);
        chk({tag, " R8 nib_rd"}, nr_bad, 0);
        chk({tag, " row strobes"}, ras_n, 5);
        if (is_rd) begin
            chk({tag, " R6 no conv"}, conv_n, 0);
            chk({tag, " R6 no we"}, we_n, 0);
            chk({tag, " R6 captures"}, cap_n, 2);
        end else begin
            chk({tag, " R5 conv count"}, conv_n, 1);
            chk({tag, " R5 conv cycle"}, conv_pos, 1);
            chk({tag, " R5 we count"}, we_n, 2);
            chk({tag, " R5 no capture"}, cap_n, 0);
        end
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 step", step, 0);
        chk("R1 strobes", {row_stb, col_stb, mem_we, cap_stb, conv_start, nib_rd, nib_wr}, 0);
        chk("R1 wr_ptr", wr_ptr, 0);
        chk("R1 rd_ptr", rd_ptr, 0);
    endtask

    task automatic t_write();
        int w; int p0 = wr_ptr;
        wr_sclk = 1'b1;
        wait_busy(1'b1, w);
        run_seq(1'b0, "write");
        chk("R7 wr_ptr +1", wr_ptr, (p0 + 1) % (1 << PW));
    endtask

    task automatic t_read();
        int w; int p0 = rd_ptr;
        rd_sclk = 1'b1;
        wait_busy(1'b1, w);
        run_seq(1'b1, "read");
        chk("R7 rd_ptr +1", rd_ptr, (p0 + 1) % (1 << PW));
    endtask

    task automatic t_idle();
        int bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy || step != 0) bad++;
        end
        chk("R2 idle at zero", bad, 0);
    endtask

    task automatic t_both();
        int w, gap = 0; int wp = wr_ptr, rp = rd_ptr;
        wr_sclk = 1'b1; rd_sclk = 1'b1;
        wait_busy(1'b1, w);
        chk("R4 write first", op_is_rd, 0);
        while (busy && gap < 40) begin @(negedge clk); gap++; end
        while (!busy && gap < 40) begin @(negedge clk); gap++; end
        chk("R10 read grant gap", gap, 11);
        chk("R4 read served", op_is_rd, 1);
        for (int i = 0; i < 11; i++) @(negedge clk);
        chk("R10 both done busy", busy, 0);
        chk("R4 wr_ptr", wr_ptr, (wp + 1) % (1 << PW));
        chk("R4 rd_ptr", rd_ptr, (rp + 1) % (1 << PW));
    endtask

    task automatic t_hold();
        int w; int p0 = wr_ptr;
        wr_sclk = 1'b1;
        wait_busy(1'b0, w);
        for (int i = 0; i < 60; i++) @(negedge clk);
        chk("R9 held clock one op", wr_ptr, (p0 + 1) % (1 << PW));
        chk("R9 not busy", busy, 0);
        wr_sclk = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge clk);
    endtask

    task automatic t_wrap();
        int w; int p0 = wr_ptr;
        for (int n = 0; n < (1 << PW); n++) begin
            wr_sclk = 1'b1;
            wait_busy(1'b1, w);
            for (int i = 0; i < 12; i++) @(negedge clk);
        end
        chk("R7 wr_ptr wraps", wr_ptr, p0);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_idle();
        t_read();
        t_both();
        t_hold();
        t_wrap();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule